// File: doc/BRIEF.md
# Tile Row Pixel Renderer

This block draws one horizontal row of a graphics tile into an on-chip line buffer. A caller supplies the tile number, the base address of the tile's graphics segment, a pixel-depth code, the tile's width and height, flip controls, a palette base, a 4-bit palette select, a drawing depth, the tile's x position on the line and the row within the tile. The block works out where that row starts in a byte-wide graphics memory, reads the row's packed bytes one per cycle, splits every group of bytes into four pens and writes each pen as a palette index into the line buffer.

Each line-buffer position holds a palette index and a depth. A pixel lands only if its depth is strictly smaller than the depth already stored there, so a line is built by clearing it once and then rendering any number of tiles in any order: the lowest depth wins at every position. A read port returns the index and depth of any position for the later colour stage.

Top module: `tile_row_render`

## Requirements
- R1: The 2-bit pixel-depth code selects the packing: code 3 gives 8-bit pens from 4 bytes per group of four pixels, code 2 gives 6-bit pens from 3 bytes per group, codes 0 and 1 give 4-bit pens from 2 bytes per group.
- R2: A row holds 4 groups (16-wide tile) or 2 groups (8-wide tile); the row byte count R is therefore 16, 12 or 8 for wide tiles and 8, 6 or 4 for narrow ones. With height H of 16 or 8, the row read starts at segment base + tile number x R x H + selected row x R, and the block requests exactly R consecutive addresses from there.
- R3: Within a group the bytes are combined little-endian (first byte in bits 7:0) and the leftmost pixel of the group takes the least significant pen field.
- R4: With vertical flip the row read is H-1-row; with horizontal flip tile pixel x is placed at offset W-1-x from the tile's x position (W is 16 or 8).
- R5: A pen of zero leaves the line buffer untouched unless the opaque input is set, in which case it is written like any other pen.
- R6: A pixel is stored only when its depth is strictly less than the depth held at its position, and the stored depth then takes the new value; equal or greater depths change nothing.
- R7: The stored index is (palette base + pen, truncated to the index width) ORed with the palette select shifted left by 4; at code 3 the select is treated as zero and at code 2 only its two upper bits (mask 4'b1100) are used.
- R8: Reset and the line-clear input set every stored depth to the maximum value (all ones), which no pixel can beat.
- R9: A pixel whose line position (x position + offset) is at or beyond the line length is discarded and alters no position.
- R10: A start pulse while idle makes busy rise on the next cycle; when the last pixel of the row has been written busy falls and done pulses for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_clear | input | 1 | Set all stored depths to maximum |
| start | input | 1 | Begin rendering a row (sampled while idle) |
| tile_num | input | TILE_W | Tile number inside the segment |
| seg_base | input | ADDR_W | Byte address of the graphics segment |
| bpp_code | input | 2 | Pixel-depth code |
| wide | input | 1 | 1: tile is 16 pixels wide, 0: 8 |
| tall | input | 1 | 1: tile is 16 rows high, 0: 8 |
| flip_x | input | 1 | Horizontal mirror |
| flip_y | input | 1 | Vertical mirror |
| row | input | 4 | Row within the tile |
| x_pos | input | X_W | Line position of the tile's left edge |
| pal_base | input | IDX_W | Palette base added to each pen |
| pal_sel | input | 4 | Palette select |
| depth | input | DEPTH_W | Drawing depth, lower wins |
| opaque | input | 1 | Draw zero pens as well |
| busy | output | 1 | A row is being rendered |
| done | output | 1 | One-cycle pulse at the end of a row |
| gfx_rd | output | 1 | Graphics memory read request |
| gfx_addr | output | ADDR_W | Graphics memory byte address |
| gfx_data | input | 8 | Byte returned one cycle after the request |
| rd_x | input | LX_W | Line-buffer read position |
| rd_index | output | IDX_W | Stored palette index (one cycle latency) |
| rd_depth | output | DEPTH_W | Stored depth (one cycle latency) |

## Verification
The bench targets the 6-bit packing, where pen fields straddle byte boundaries and a design that assembled bytes big-endian or stepped the field by the wrong width would show scrambled indices. It draws tiles at equal, lower and higher depth over earlier ones, so a compare written as less-or-equal would let a second tile overwrite an equal-depth one. Transparent rows drawn with and without the opaque flag expose a design that skips or writes zero pens wrongly, and tiles placed near and past the line end catch one that wraps clipped pixels back to the line start. Every row's read addresses are compared with the computed start and byte count, which catches a wrong row size, tile size or flipped row.

// File: rtl/tr_pkg.sv
package tr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_DRAIN = 2'd2,
    ST_PIX   = 2'd3
  } tr_state_e;

  // Palette select as seen by a given pixel depth
  function automatic logic [3:0] eff_select(input logic [1:0] bpp, input logic [3:0] sel);
    if (bpp == 2'd3)      return 4'd0;
    else if (bpp == 2'd2) return sel & 4'b1100;
    else                  return sel;
  endfunction

endpackage

// File: rtl/tr_addr.sv
module tr_addr #(
  parameter int ADDR_W = 25,
  parameter int TILE_W = 12
) (
  input  logic [TILE_W-1:0] tile_num,
  input  logic [ADDR_W-1:0] seg_base,
  input  logic [1:0]        bpp_code,
  input  logic              wide,
  input  logic              tall,
  input  logic              flip_y,
  input  logic [3:0]        row,
  output logic [ADDR_W-1:0] row_start,
  output logic [2:0]        grp_bytes,
  output logic [4:0]        row_bytes,
  output logic [1:0]        last_grp
);

  logic [8:0] tile_bytes;
  logic [3:0] eff_row;
  logic [7:0] row_off;

  always_comb begin
    case (bpp_code)
      2'd3:    grp_bytes = 3'd4;
      2'd2:    grp_bytes = 3'd3;
      default: grp_bytes = 3'd2;
    endcase
    row_bytes  = wide ? {grp_bytes, 2'b00} : {1'b0, grp_bytes, 1'b0};
    tile_bytes = tall ? {row_bytes, 4'b0000} : {1'b0, row_bytes, 3'b000};
    if (tall) eff_row = flip_y ? (4'd15 - row) : row;
    else      eff_row = {1'b0, flip_y ? (3'd7 - row[2:0]) : row[2:0]};
    row_off  = {4'b0000, eff_row} * {3'b000, row_bytes};
    last_grp = wide ? 2'd3 : 2'd1;
  end

  assign row_start = seg_base + (ADDR_W'(tile_num) * ADDR_W'(tile_bytes)) + ADDR_W'(row_off);

endmodule

// File: rtl/tr_unpack.sv
module tr_unpack (
  input  logic [31:0] grp,
  input  logic [1:0]  bpp_code,
  input  logic [1:0]  slot,
  output logic [7:0]  pen
);

  always_comb begin
    case (bpp_code)
      2'd3:    pen = grp[slot*8 +: 8];
      2'd2:    pen = {2'b00, grp[slot*6 +: 6]};
      default: pen = {4'b0000, grp[slot*4 +: 4]};
    endcase
  end

endmodule

// File: rtl/tr_linebuf.sv
module tr_linebuf #(
  parameter int LINE_LEN = 256,
  parameter int SX_W     = 10,
  parameter int DEPTH_W  = 3,
  parameter int IDX_W    = 9,
  localparam int LX_W    = $clog2(LINE_LEN)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               wr_en,
  input  logic [SX_W-1:0]    wr_x,
  input  logic [DEPTH_W-1:0] wr_depth,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [LX_W-1:0]    rd_x,
  output logic [IDX_W-1:0]   rd_idx,
  output logic [DEPTH_W-1:0] rd_dep
);

  localparam logic [DEPTH_W-1:0] DMAX = '1;

  logic [DEPTH_W-1:0] dep_q [LINE_LEN];
  logic [IDX_W-1:0]   idx_mem [LINE_LEN];
  logic [LX_W-1:0]    wa;
  logic               in_line;
  logic               wr_ok;

  assign wa      = wr_x[LX_W-1:0];
  assign in_line = (wr_x < SX_W'(LINE_LEN));
  assign wr_ok   = wr_en && in_line && !clr && (wr_depth < dep_q[wa]);

  // Depth store: reset and clear to the maximum value
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINE_LEN; i++) dep_q[i] <= DMAX;
      rd_dep <= DMAX;
    end else begin
      if (clr) begin
        for (int i = 0; i < LINE_LEN; i++) dep_q[i] <= DMAX;
      end else if (wr_ok) begin
        dep_q[wa] <= wr_depth;
      end
      rd_dep <= dep_q[rd_x];
    end
  end

  // Index store: plain RAM, one write and one registered read port
  always_ff @(posedge clk) begin
    if (wr_ok) idx_mem[wa] <= wr_idx;
    rd_idx <= idx_mem[rd_x];
  end

  p_depth_min_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && in_line && !clr) |=> (dep_q[$past(wa)] <= $past(wr_depth)) &&
                                   (dep_q[$past(wa)] <= $past(dep_q[wa])));

  p_clear_max_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (dep_q[0] == DMAX) && (dep_q[LINE_LEN-1] == DMAX));

  p_clip_keep_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !in_line && !clr) |=> dep_q[$past(wa)] == $past(dep_q[wa]));

endmodule

// File: rtl/tile_row_render.sv
module tile_row_render
  import tr_pkg::*;
#(
  parameter int ADDR_W   = 25,
  parameter int TILE_W   = 12,
  parameter int X_W      = 9,
  parameter int LINE_LEN = 256,
  parameter int DEPTH_W  = 3,
  parameter int IDX_W    = 9,
  localparam int LX_W    = $clog2(LINE_LEN),
  localparam int SX_W    = X_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               line_clear,
  input  logic               start,
  input  logic [TILE_W-1:0]  tile_num,
  input  logic [ADDR_W-1:0]  seg_base,
  input  logic [1:0]         bpp_code,
  input  logic               wide,
  input  logic               tall,
  input  logic               flip_x,
  input  logic               flip_y,
  input  logic [3:0]         row,
  input  logic [X_W-1:0]     x_pos,
  input  logic [IDX_W-1:0]   pal_base,
  input  logic [3:0]         pal_sel,
  input  logic [DEPTH_W-1:0] depth,
  input  logic               opaque,
  output logic               busy,
  output logic               done,
  output logic               gfx_rd,
  output logic [ADDR_W-1:0]  gfx_addr,
  input  logic [7:0]         gfx_data,
  input  logic [LX_W-1:0]    rd_x,
  output logic [IDX_W-1:0]   rd_index,
  output logic [DEPTH_W-1:0] rd_depth
);

  tr_state_e          state_q;
  logic [ADDR_W-1:0]  start_w, row_start_q, addr_q;
  logic [2:0]         grpb_w, grpb_q;
  logic [4:0]         rb_w, rb_q;
  logic [1:0]         lastg_w, lastg_q;
  logic [1:0]         bpp_q, j_q, req_j_q, g_q, p_q;
  logic               wide_q, flipx_q, opq_q, req_vld_q, done_q;
  logic [X_W-1:0]     x_q;
  logic [IDX_W-1:0]   palb_q;
  logic [3:0]         sel_q;
  logic [DEPTH_W-1:0] tdep_q;
  logic [31:0]        grp_q;

  tr_addr #(.ADDR_W(ADDR_W), .TILE_W(TILE_W)) u_addr (
    .tile_num (tile_num), .seg_base (seg_base), .bpp_code (bpp_code),
    .wide (wide), .tall (tall), .flip_y (flip_y), .row (row),
    .row_start (start_w), .grp_bytes (grpb_w), .row_bytes (rb_w), .last_grp (lastg_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;  done_q <= 1'b0;  req_vld_q <= 1'b0;
      row_start_q <= '0;   addr_q <= '0;    grpb_q <= 3'd2;  rb_q <= 5'd4;
      lastg_q <= '0;  bpp_q <= '0;  j_q <= '0;  req_j_q <= '0;  g_q <= '0;  p_q <= '0;
      wide_q <= 1'b0; flipx_q <= 1'b0; opq_q <= 1'b0; x_q <= '0; palb_q <= '0;
      sel_q <= '0;    tdep_q <= '1;    grp_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (req_vld_q) grp_q[req_j_q*8 +: 8] <= gfx_data;
      case (state_q)
        ST_IDLE: if (start) begin
          row_start_q <= start_w;  addr_q <= start_w;
          grpb_q <= grpb_w;  rb_q <= rb_w;  lastg_q <= lastg_w;
          bpp_q <= bpp_code; wide_q <= wide; flipx_q <= flip_x; opq_q <= opaque;
          x_q <= x_pos;  palb_q <= pal_base;  tdep_q <= depth;
          sel_q <= eff_select(bpp_code, pal_sel);
          j_q <= '0;  g_q <= '0;
          state_q <= ST_FETCH;
        end
        ST_FETCH: begin
          req_vld_q <= 1'b1;
          req_j_q   <= j_q;
          addr_q    <= addr_q + 1'b1;
          if ({1'b0, j_q} == grpb_q - 3'd1) state_q <= ST_DRAIN;
          else                              j_q <= j_q + 1'b1;
        end
        ST_DRAIN: begin
          req_vld_q <= 1'b0;
          p_q       <= '0;
          state_q   <= ST_PIX;
        end
        ST_PIX: begin
          p_q <= p_q + 1'b1;
          if (p_q == 2'd3) begin
            if (g_q == lastg_q) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              g_q     <= g_q + 1'b1;
              j_q     <= '0;
              state_q <= ST_FETCH;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Pixel datapath: pen extraction, mirroring, index formation
  logic [7:0]       pen;
  logic [3:0]       xt, xm;
  logic [SX_W-1:0]  sx;
  logic [IDX_W-1:0] idx;
  logic             pix_we;

  tr_unpack u_unpack (.grp (grp_q), .bpp_code (bpp_q), .slot (p_q), .pen (pen));

  assign xt     = {g_q, p_q};
  assign xm     = flipx_q ? ((wide_q ? 4'd15 : 4'd7) - xt) : xt;
  assign sx     = {1'b0, x_q} + SX_W'(xm);
  assign idx    = (palb_q + IDX_W'(pen)) | IDX_W'({sel_q, 4'b0000});
  assign pix_we = (state_q == ST_PIX) && (opq_q || (pen != 8'd0));

  tr_linebuf #(.LINE_LEN(LINE_LEN), .SX_W(SX_W), .DEPTH_W(DEPTH_W), .IDX_W(IDX_W)) u_line (
    .clk (clk), .rst (rst), .clr (line_clear),
    .wr_en (pix_we), .wr_x (sx), .wr_depth (tdep_q), .wr_idx (idx),
    .rd_x (rd_x), .rd_idx (rd_index), .rd_dep (rd_depth)
  );

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign gfx_rd   = (state_q == ST_FETCH);
  assign gfx_addr = addr_q;

  p_addr_range_r2: assert property (@(posedge clk) disable iff (rst)
    gfx_rd |-> ((gfx_addr - row_start_q) < ADDR_W'(rb_q)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_busy_rise_r10: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

// File: tb/test_tile_row_render.sv
`timescale 1ns/1ps
module test_tile_row_render;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_clear = 1'b0, start = 1'b0;
  logic [11:0] tile_num = '0;
  logic [24:0] seg_base = '0;
  logic [1:0]  bpp_code = '0;
  logic        wide = 0, tall = 0, flip_x = 0, flip_y = 0, opaque = 0;
  logic [3:0]  row = '0, pal_sel = '0;
  logic [8:0]  x_pos = '0, pal_base = '0;
  logic [2:0]  depth = '0;
  logic        busy, done, gfx_rd;
  logic [24:0] gfx_addr;
  logic [7:0]  gfx_data = '0;
  logic [7:0]  rd_x = '0;
  logic [8:0]  rd_index;
  logic [2:0]  rd_depth;

  int checks = 0, errors = 0;
  logic [7:0] gmem [4096];
  logic [8:0] ref_idx [256];
  logic [2:0] ref_dep [256];

  always #10 clk = ~clk;

  tile_row_render i_tile_row_render (
    .clk, .rst, .line_clear, .start, .tile_num, .seg_base, .bpp_code, .wide, .tall,
    .flip_x, .flip_y, .row, .x_pos, .pal_base, .pal_sel, .depth, .opaque,
    .busy, .done, .gfx_rd, .gfx_addr, .gfx_data, .rd_x, .rd_index, .rd_depth
  );

  always @(posedge clk) gfx_data <= gmem[gfx_addr[11:0]];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ref_pen(input int st, input int bpp, input int xt);
    int nb = (bpp == 3) ? 4 : (bpp == 2) ? 3 : 2;
    int g = xt / 4, p = xt % 4;
    logic [31:0] w = '0;
    for (int k = 0; k < nb; k++) w = w | (32'(gmem[(st + g*nb + k) & 4095]) << (8*k));
    if (bpp == 3) return int'((w >> (8*p)) & 32'hff);
    if (bpp == 2) return int'((w >> (6*p)) & 32'h3f);
    return int'((w >> (4*p)) & 32'hf);
  endfunction

  task automatic do_clear();
    @(negedge clk) line_clear = 1'b1;
    @(negedge clk) line_clear = 1'b0;
    for (int i = 0; i < 256; i++) ref_dep[i] = 3'd7;
  endtask

  task automatic render(input int tl, input int sg, input int bpp, input int wd, input int tll,
                        input int fx, input int fy, input int rw, input int x, input int pb,
                        input int sl, input int dp, input int op);
    int rb = ((bpp == 3) ? 8 : (bpp == 2) ? 6 : 4) * (wd ? 2 : 1);
    int h = tll ? 16 : 8, w = wd ? 16 : 8;
    int r = rw % h;
    int er = fy ? (h - 1 - r) : r;
    int st = sg + tl*rb*h + er*rb;
    int es = (bpp == 3) ? 0 : (bpp == 2) ? (sl & 12) : sl;
    int n = 0, first = -1, cyc = 0;
    bit seen_done = 0;
    for (int xt = 0; xt < w; xt++) begin
      int pen = ref_pen(st, bpp, xt);
      int sx = x + (fx ? (w - 1 - xt) : xt);
      if ((op != 0 || pen != 0) && sx < 256 && dp < int'(ref_dep[sx])) begin
        ref_dep[sx] = 3'(dp);
        ref_idx[sx] = 9'((pb + pen) & 511) | 9'(es << 4);
      end
    end
    @(negedge clk);
    tile_num = 12'(tl); seg_base = 25'(sg); bpp_code = 2'(bpp); wide = wd[0]; tall = tll[0];
    flip_x = fx[0]; flip_y = fy[0]; row = 4'(rw); x_pos = 9'(x); pal_base = 9'(pb);
    pal_sel = 4'(sl); depth = 3'(dp); opaque = op[0]; start = 1'b1;
    while (!seen_done && cyc < 200) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
      if (gfx_rd) begin
        if (n == 0) first = int'(gfx_addr);
        else if (int'(gfx_addr) != first + n) first = -2;
        n++;
      end
      if (cyc == 1) chk(busy == 1'b1, "R10 busy after start", int'(busy), 1);
      if (done) seen_done = 1;
    end
    chk(first == st, "R2 row start address", first, st);
    chk(n == rb, "R2 row byte count", n, rb);
    chk(seen_done && !busy, "R10 done and idle", int'(busy), 0);
    @(negedge clk);
    chk(!done, "R10 done single cycle", int'(done), 0);
  endtask

  task automatic sweep(input string tag);
    int bad = 0, bx = 0, ba = 0, be = 0;
    for (int x = 0; x < 256; x++) begin
      @(negedge clk) rd_x = 8'(x);
      @(negedge clk);
      if (rd_depth != ref_dep[x]) begin
        if (bad == 0) begin bx = x; ba = int'(rd_depth); be = int'(ref_dep[x]); end
        bad++;
      end else if (ref_dep[x] != 3'd7 && rd_index != ref_idx[x]) begin
        if (bad == 0) begin bx = x; ba = int'(rd_index); be = int'(ref_idx[x]); end
        bad++;
      end
    end
    if (bad != 0) $display("  line mismatch at x=%0d (%0d positions)", bx, bad);
    chk(bad == 0, tag, ba, be);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) begin
      int r = int'($urandom);
      gmem[i] = ((r & 3) == 0) ? 8'h00 : 8'(r >>> 8);
    end
    for (int i = 0; i < 256; i++) begin gmem[12'hC00 + i] = 8'h00; ref_dep[i] = 3'd7; ref_idx[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!busy && !done && !gfx_rd, "R10 idle after reset", int'(busy), 0);
    sweep("R8 depths at maximum after reset");

    // R1 R3 R7: 8-bit pens, select forced to zero
    render(3, 'h200, 3, 1, 1, 0, 0, 5, 0, 'h100, 15, 2, 0);
    // R1 R4 R7: 6-bit pens with vertical flip, upper select bits only
    render(6, 'h000, 2, 0, 1, 0, 1, 2, 40, 'h000, 15, 1, 1);
    // R1 R4: 4-bit pens with horizontal flip
    render(2, 'h400, 1, 1, 0, 1, 0, 7, 80, 'h020, 9, 3, 1);
    render(1, 'h600, 0, 0, 0, 1, 1, 0, 120, 'h000, 6, 4, 0);
    sweep("R1 R3 R4 R7 mixed packing and flips");

    // R5: transparent row, then the same row opaque
    render(0, 'hC00, 1, 1, 0, 0, 0, 1, 40, 'h000, 3, 0, 0);
    sweep("R5 zero pens skipped");
    render(0, 'hC00, 1, 1, 0, 0, 0, 1, 160, 'h0AA, 3, 0, 1);
    sweep("R5 zero pens drawn when opaque");

    // R6: equal, higher and lower depths over an existing tile
    do_clear();
    sweep("R8 depths at maximum after clear");
    render(1, 'h000, 1, 0, 0, 0, 0, 3, 20, 'h000, 2, 3, 1);
    render(2, 'h000, 1, 0, 0, 0, 0, 4, 20, 'h050, 5, 3, 1);
    sweep("R6 equal depth does not overwrite");
    render(3, 'h200, 1, 0, 0, 0, 0, 4, 20, 'h050, 5, 5, 1);
    sweep("R6 higher depth does not overwrite");
    render(4, 'h200, 1, 0, 0, 0, 0, 4, 20, 'h050, 5, 2, 1);
    sweep("R6 lower depth overwrites");

    // R9: partial tile at the line end, tile wholly beyond it
    do_clear();
    render(5, 'h400, 3, 1, 0, 0, 0, 1, 250, 'h000, 0, 1, 1);
    render(5, 'h400, 2, 1, 0, 1, 0, 1, 300, 'h000, 0, 0, 1);
    sweep("R9 pixels past line end discarded");

    for (int ln = 0; ln < 25; ln++) begin
      do_clear();
      for (int t = 0; t < 3; t++)
        render(int'($urandom_range(7)), int'($urandom_range(3)) * 'h200, int'($urandom_range(3)),
               int'($urandom_range(1)), int'($urandom_range(1)), int'($urandom_range(1)),
               int'($urandom_range(1)), int'($urandom_range(15)), int'($urandom_range(270)),
               int'($urandom_range(511)), int'($urandom_range(15)), int'($urandom_range(6)),
               int'($urandom_range(1)));
      sweep("R1 R3 R4 R5 R6 R7 R9 random line");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule